// File: doc/BRIEF.md
# BCD Calendar Register Bank

This block keeps time of day and calendar date in packed BCD and shows them to software as eight byte-wide registers behind a 3-bit offset. These are the top eight bytes of a 2K byte map. A one-cycle tick enable, asserted once per second, advances a set of live counters: seconds, minutes, hours (24-hour), day of week, date, month and a two-digit year. Software never reads the live counters directly. One clock cycle after every tick that advances them, their values are copied into a bank of holding registers, and the access port reads and writes those.

Two bits of the control byte change the copy. The read-hold bit freezes the holding registers so that software gets a consistent time while the live counters keep running. The write-hold bit also suspends the copy. Clearing it loads the holding registers into the live counters, which is how the time is set. A stop flag in the seconds byte halts counting, and a frequency-test flag sits in the day byte. The calibration sign and magnitude are stored in the control byte and brought out on output pins for a prescaler outside this block.

Top module: `rtc_calendar_bank`

## Requirements
- R1: After reset, the bytes read back as follows. Offset 0 (control) reads 00. Seconds (1), minutes (2) and hours (3) read 00. Day of week (4), date (5) and month (6) read 01. Year (7) reads 00. Both calibration outputs are 0.
- R2: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00, and that wrap increments both the date and the day of week. The day of week wraps from 7 to 1.
- R3: The date wraps to 01 after the last day of the month: 31 for months 01, 03, 05, 07, 08, 10 and 12, 30 for months 04, 06, 09 and 11, and 28 for month 02. February has 29 days when the BCD year, taken as a decimal number, is divisible by 4.
- R4: The month wraps from 12 to 01 and increments the year. The year wraps from 99 to 00.
- R5: The holding registers take the live counter values on the clock cycle after a tick on which the counters advance. A read returns the addressed byte on acc_rdata one cycle after the read request.
- R6: While control bit 6 (read-hold) is 1, no copy into the holding registers takes place, but the live counters keep advancing. After the bit is cleared, the next tick shows the current live time.
- R7: While control bit 7 (write-hold) is 1, copying is suspended. A control write that changes bit 7 from 1 to 0 loads the holding registers at offsets 1 to 7 into the live counters, and counting continues from the loaded values.
- R8: Bit 7 of offset 1 is the stop flag. It is written directly, without write-hold. While it is 1, ticks do not advance the counters and no copy occurs. When it is cleared, the next tick advances the counters again.
- R9: Bit 6 of offset 4 is the frequency-test flag. It is written directly and reads back. Bits with no meaning read as 0: hours bits 7:6, day-of-week bits 7 and 5:3, date bits 7:6, month bits 7:5, and seconds and minutes bit 7, except for the stop flag.
- R10: Control bit 5 (sign) drives cal_sign and control bits 4:0 drive cal_mag. The whole control byte reads back unchanged.
- R11: A field that was loaded with a value at or above its maximum returns to its minimum on its next increment and carries into the next field.
- R12: Setting read-hold in the same cycle as a tick does not cancel the copy that follows that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| acc_en | input | 1 | Access request |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register offset (0 = control, 1..7 = seconds to year) |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Registered read data, valid one cycle after a read |
| cal_sign | output | 1 | Calibration sign from control bit 5 |
| cal_mag | output | 5 | Calibration magnitude from control bits 4:0 |

## Verification
The calendar is swept over the last second of every month in eight different years: four consecutive years cover all leap-year residues, and one is the year 99. Each point starts at the month's last day at 23:59:59 and checks every field after a single tick. This separates month-length and leap-year decode errors from carry-chain errors. The single-field patterns are a seconds rollover, an out-of-range seconds load, and a tick that lands on the same cycle as setting a hold. They separate the wrap compare from the copy timing. Hold, stop and load sequences compare the holding bytes with the live time that the load proves is running underneath.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int REG_CNT   = 1 << ADDR_W;
  localparam int FIELD_CNT = REG_CNT - 1;

  // field index = register offset - 1
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  localparam int CTRL_WHOLD = 7;
  localparam int CTRL_RHOLD = 6;
  localparam int CTRL_SIGN  = 5;
  localparam int CAL_W      = 5;
  localparam int STOP_BIT   = 7;
  localparam int FTEST_BIT  = 6;

  typedef logic [DATA_W-1:0] byte_t;
  typedef byte_t [FIELD_CNT-1:0] tvec_t;

  function automatic byte_t field_mask(input int idx);
    case (idx)
      F_SEC, F_MIN:   return 8'h7F;
      F_HOUR, F_DATE: return 8'h3F;
      F_DOW:          return 8'h07;
      F_MON:          return 8'h1F;
      default:        return 8'hFF;
    endcase
  endfunction

  function automatic byte_t field_max(input int idx);
    case (idx)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR:       return 8'h23;
      F_DOW:        return 8'h07;
      F_DATE:       return 8'h31;
      F_MON:        return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction

  function automatic byte_t field_min(input int idx);
    case (idx)
      F_DOW, F_DATE, F_MON: return 8'h01;
      default:              return 8'h00;
    endcase
  endfunction

  function automatic byte_t bcd_inc(input byte_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic byte_t month_days(input byte_t mon, input byte_t yr);
    int yb;
    yb = int'(yr[7:4]) * 10 + int'(yr[3:0]);
    case (mon)
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      8'h02:                      return ((yb % 4) == 0) ? 8'h29 : 8'h28;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtcb_counters.sv
module rtcb_counters
  import rtcb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  stop,
  input  logic  load,
  input  tvec_t load_val,
  output tvec_t live,
  output logic  adv
);
  logic [FIELD_CNT-1:0] wrap;
  logic [FIELD_CNT-1:0] carry;
  byte_t                lim [FIELD_CNT];

  assign adv = tick & ~stop & ~load;

  always_comb begin
    for (int i = 0; i < FIELD_CNT; i++) begin
      lim[i]  = (i == F_DATE) ? month_days(live[F_MON], live[F_YEAR]) : field_max(i);
      wrap[i] = (live[i] >= lim[i]);
    end
    carry[F_SEC]  = adv;
    carry[F_MIN]  = carry[F_SEC]  & wrap[F_SEC];
    carry[F_HOUR] = carry[F_MIN]  & wrap[F_MIN];
    carry[F_DOW]  = carry[F_HOUR] & wrap[F_HOUR];
    carry[F_DATE] = carry[F_HOUR] & wrap[F_HOUR];
    carry[F_MON]  = carry[F_DATE] & wrap[F_DATE];
    carry[F_YEAR] = carry[F_MON]  & wrap[F_MON];
  end

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_field
    localparam byte_t MSK = field_mask(g);
    localparam byte_t LOW = field_min(g);
    always_ff @(posedge clk) begin
      if (rst)            live[g] <= LOW;
      else if (load)      live[g] <= load_val[g] & MSK;
      else if (carry[g])  live[g] <= wrap[g] ? LOW : (bcd_inc(live[g]) & MSK);
    end
  end

  // R8
  stop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (stop && !load) |=> $stable(live));
  // R7
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (live[F_SEC] == ($past(load_val[F_SEC]) & 8'h7F)) &&
             (live[F_YEAR] == $past(load_val[F_YEAR])));
  // R2
  hour_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && live[F_SEC] == 8'h59 && live[F_MIN] == 8'h59 && live[F_HOUR] == 8'h23)
    |=> (live[F_HOUR] == 8'h00) && (live[F_DATE] != $past(live[F_DATE])));
endmodule

// File: rtl/rtcb_holding.sv
module rtcb_holding
  import rtcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             wdata,
  input  logic              adv,
  input  tvec_t             live,
  output tvec_t             hold,
  output byte_t             ctrl,
  output logic              stop,
  output logic              ftest,
  output logic              load
);
  logic copy_go;
  logic ctrl_wr;

  assign ctrl_wr = wr_en && (addr == '0);
  assign load    = ctrl_wr && ctrl[CTRL_WHOLD] && !wdata[CTRL_WHOLD];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      copy_go <= 1'b0;
      stop    <= 1'b0;
      ftest   <= 1'b0;
    end else begin
      copy_go <= adv && !ctrl[CTRL_RHOLD] && !ctrl[CTRL_WHOLD];
      if (ctrl_wr) ctrl <= wdata;
      if (wr_en && addr == ADDR_W'(F_SEC + 1)) stop  <= wdata[STOP_BIT];
      if (wr_en && addr == ADDR_W'(F_DOW + 1)) ftest <= wdata[FTEST_BIT];
    end
  end

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_hold
    localparam byte_t MSK = field_mask(g);
    always_ff @(posedge clk) begin
      if (rst)                                  hold[g] <= field_min(g);
      else if (wr_en && addr == ADDR_W'(g + 1)) hold[g] <= wdata & MSK;
      else if (copy_go)                         hold[g] <= live[g];
    end
  end

  // R5 / R12
  copy_take_chk: assert property (@(posedge clk) disable iff (rst)
    (copy_go && !wr_en) |=> (hold == $past(live)));
  // R6
  rhold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl[CTRL_RHOLD] && !copy_go && !wr_en) |=> $stable(hold));
endmodule

// File: rtl/rtcb_readport.sv
module rtcb_readport
  import rtcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             ctrl,
  input  tvec_t             hold,
  input  logic              stop,
  input  logic              ftest,
  output byte_t             rdata
);
  byte_t view [REG_CNT];

  always_comb begin
    view[0] = ctrl;
    for (int i = 0; i < FIELD_CNT; i++) view[i+1] = hold[i];
    view[F_SEC+1][STOP_BIT]  = stop;
    view[F_DOW+1][FTEST_BIT] = ftest;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= view[addr];
  end

  // R9
  hour_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(F_HOUR + 1)) |=> (rdata[7:6] == 2'b00));
  // R9
  month_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(F_MON + 1)) |=> (rdata[7:5] == 3'b000));
endmodule

// File: rtl/rtc_calendar_bank.sv
module rtc_calendar_bank
  import rtcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              cal_sign,
  output logic [CAL_W-1:0]  cal_mag
);
  tvec_t live, hold;
  byte_t ctrl;
  logic  stop, ftest, load, adv;

  rtcb_counters u_cnt (
    .clk(clk), .rst(rst), .tick(tick_1hz), .stop(stop), .load(load),
    .load_val(hold), .live(live), .adv(adv)
  );

  rtcb_holding u_hold (
    .clk(clk), .rst(rst), .wr_en(acc_en && acc_wr), .addr(acc_addr),
    .wdata(acc_wdata), .adv(adv), .live(live), .hold(hold), .ctrl(ctrl),
    .stop(stop), .ftest(ftest), .load(load)
  );

  rtcb_readport u_rd (
    .clk(clk), .rst(rst), .rd_en(acc_en && !acc_wr), .addr(acc_addr),
    .ctrl(ctrl), .hold(hold), .stop(stop), .ftest(ftest), .rdata(acc_rdata)
  );

  assign cal_sign = ctrl[CTRL_SIGN];
  assign cal_mag  = ctrl[CAL_W-1:0];

  // R10
  cal_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_wr && acc_addr == '0) |=> (cal_mag == $past(acc_wdata[CAL_W-1:0])));
endmodule

// File: tb/rtc_calendar_bank_tb.sv
module rtc_calendar_bank_tb_top;
  logic       clk = 0;
  logic       rst = 1;
  logic       tick_1hz = 0;
  logic       acc_en = 0, acc_wr = 0;
  logic [2:0] acc_addr = 0;
  logic [7:0] acc_wdata = 0;
  logic [7:0] acc_rdata;
  logic       cal_sign;
  logic [4:0] cal_mag;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  rtc_calendar_bank dut_i (.*);

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); acc_en = 1; acc_wr = 1; acc_addr = 3'(a); acc_wdata = d;
    @(negedge clk); acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); acc_en = 1; acc_wr = 0; acc_addr = 3'(a);
    @(negedge clk); acc_en = 0; d = acc_rdata;
  endtask

  task automatic tick1();
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, dw, h, mi, s);
    wr(0, 8'h80);
    wr(7, y); wr(6, mo); wr(5, d); wr(4, dw); wr(3, h); wr(2, mi); wr(1, s);
    wr(0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, a, b, c, e;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      chk($sformatf("R1 reset offset %0d", i), v, (i >= 4 && i <= 6) ? 8'h01 : 8'h00);
    end
    chk("R1 cal outputs", {cal_sign, cal_mag}, 0);

    // R2 seconds to minutes carry
    set_time(8'h10, 8'h05, 8'h10, 8'h03, 8'h00, 8'h00, 8'h58);
    tick1(); rd(1, v); chk("R2 sec 58->59", v, 8'h59);
    tick1(); rd(1, v); rd(2, a); chk("R2 sec 59->00 carry", {v, a}, {8'h00, 8'h01});

    // R2 hour wrap, day of week 7->1
    set_time(8'h10, 8'h05, 8'h10, 8'h07, 8'h23, 8'h59, 8'h59);
    tick1(); rd(3, v); rd(4, a); rd(5, b);
    chk("R2 hour wrap dow/date", {v, a, b}, {8'h00, 8'h01, 8'h11});

    // R3 / R4 sweep: last second of every month over several years
    for (int k = 0; k < 8; k++) begin
      for (int m = 1; m <= 12; m++) begin
        int y, d0, ey, em, ed, ew;
        y  = (k == 7) ? 99 : k;
        d0 = (m % 7) + 1;
        set_time(bcd(y), bcd(m), bcd(dim(m, y)), bcd(d0), 8'h23, 8'h59, 8'h59);
        tick1();
        ed = 1; em = (m == 12) ? 1 : m + 1;
        ey = (m == 12) ? (y + 1) % 100 : y;
        ew = (d0 == 7) ? 1 : d0 + 1;
        rd(5, v); rd(6, a); rd(7, b); rd(4, c); rd(3, e);
        chk($sformatf("R3 R4 month end y=%0d m=%0d", y, m), {v, a, b, c, e},
            {bcd(ed), bcd(em), bcd(ey), bcd(ew), 8'h00});
      end
    end

    // R11 out-of-range seconds load wraps on next increment
    set_time(8'h20, 8'h03, 8'h03, 8'h02, 8'h04, 8'h10, 8'h75);
    tick1(); rd(1, v); rd(2, a); chk("R11 sec 75 wraps", {v, a}, {8'h00, 8'h11});

    // R5 copy one cycle after tick, read latency one cycle
    set_time(8'h20, 8'h03, 8'h03, 8'h02, 8'h04, 8'h10, 8'h05);
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0; acc_en = 1; acc_wr = 0; acc_addr = 3'd1;
    @(negedge clk); acc_en = 0; v = acc_rdata;
    chk("R5 read on copy edge shows old", v, 8'h05);
    rd(1, v); chk("R5 copy visible next", v, 8'h06);

    // R6 read-hold freezes snapshot, live keeps running
    set_time(8'h20, 8'h03, 8'h03, 8'h02, 8'h04, 8'h10, 8'h10);
    wr(0, 8'h40);
    tick1(); tick1(); tick1();
    rd(1, v); chk("R6 frozen under read-hold", v, 8'h10);
    wr(0, 8'h00); tick1();
    rd(1, v); chk("R6 live kept running", v, 8'h14);

    // R12 hold set on the tick cycle keeps that copy
    set_time(8'h20, 8'h03, 8'h03, 8'h02, 8'h04, 8'h10, 8'h20);
    @(negedge clk); tick_1hz = 1; acc_en = 1; acc_wr = 1; acc_addr = 0; acc_wdata = 8'h40;
    @(negedge clk); tick_1hz = 0; acc_en = 0; acc_wr = 0;
    @(negedge clk);
    rd(1, v); chk("R12 copy not cancelled", v, 8'h21);
    tick1(); rd(1, v); chk("R12 hold effective after", v, 8'h21);
    wr(0, 8'h00); tick1(); rd(1, v); chk("R12 released", v, 8'h23);

    // R7 write-hold suspends copy, release loads counters
    set_time(8'h20, 8'h03, 8'h03, 8'h02, 8'h04, 8'h10, 8'h20);
    wr(0, 8'h80); tick1(); tick1();
    rd(1, v); chk("R7 copy suspended", v, 8'h20);
    wr(1, 8'h30); wr(0, 8'h00);
    rd(1, v); rd(2, a); chk("R7 after load", {v, a}, {8'h30, 8'h10});
    tick1(); rd(1, v); chk("R7 counting from load", v, 8'h31);

    // R8 stop flag
    set_time(8'h20, 8'h03, 8'h03, 8'h02, 8'h04, 8'h10, 8'h10);
    wr(1, 8'h90); rd(1, v); chk("R8 stop reads back", v, 8'h90);
    tick1(); tick1(); tick1();
    rd(1, v); chk("R8 stopped no advance", v, 8'h90);
    wr(1, 8'h10); tick1(); rd(1, v); chk("R8 resumes", v, 8'h11);

    // R9 frequency-test flag and padding bits
    wr(4, 8'hFF); rd(4, v); chk("R9 ftest + dow mask", v, 8'h47);
    wr(3, 8'hFF); rd(3, v); chk("R9 hour pad bits", v, 8'h3F);
    wr(6, 8'hFF); rd(6, v); chk("R9 month pad bits", v, 8'h1F);
    wr(2, 8'hFF); rd(2, v); chk("R9 minute pad bit", v, 8'h7F);
    wr(4, 8'h02); rd(4, v); chk("R9 ftest cleared", v, 8'h02);

    // R10 calibration field
    wr(0, 8'h3A); rd(0, v);
    chk("R10 cal outputs and readback", {cal_sign, cal_mag, v}, {1'b1, 5'h1A, 8'h3A});
    wr(0, 8'h15);
    chk("R10 negative sign", {cal_sign, cal_mag}, {1'b0, 5'h15});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule